// File: doc/BRIEF.md
# Asynchronous SRAM Bus Protocol Monitor

This block watches the strobe, address and host-drive lines of an asynchronous static RAM bus without taking part in it. A sampling clock that runs much faster than the bus cycle takes every pin through a two-stage synchroniser. The block then sorts each sample into one of five bus modes. It also finds the points where a write begins and ends, and times the write against minimum limits that are given in sample-clock cycles.

The RAM is selected only when the active-low select is low and the active-high select is high. A write is in progress while the chip is selected and the write strobe is low. The write therefore starts on the last of those three conditions to become true and ends on the first to become false. The write pulse width, the select width, address stability during the write and address hold after the write are all checked against these points. A read while the host still drives the data lines is reported as a bus conflict. Every violation sets a sticky flag and, if it is the first since the last clear, a 3-bit code. A verification environment or a debug fabric reads these results.

Top module: `sram_bus_monitor`

## Requirements
- R1: `mode_o` encodes the sampled bus state as follows. 0 means deselected (active-low select high, or active-high select low). 3 means write (selected and write strobe low, whatever the read enable). 2 means read (selected, write strobe high, read enable low, host not driving). 1 means output disabled (selected, both strobes high).
- R2: A sample in read mode with `host_drive_i` high gives `mode_o` = 4 (conflict) and sets error flag bit 4.
- R3: The block samples every pin input on a clock edge. The effect of that sample shows on the outputs after the third rising edge, counting the sampling edge as the first. `err_clear_i` is not synchronised and acts on the edge that samples it.
- R4: `wr_start_o` pulses for one cycle on the first sample in which selected-and-write-strobe-low holds after a sample in which it did not, and `mode_o` is 3 in that cycle.
- R5: `wr_end_o` pulses for one cycle on the first sample in which that write condition no longer holds after a sample in which it did. Whichever of the three strobes releases first ends the write.
- R6: At write end, error flag bit 0 is set if the write lasted fewer than `MIN_WR_PULSE` samples.
- R7: At write end, error flag bit 1 is set if the chip had been selected for fewer than `MIN_SEL_WIDTH` samples before the end sample.
- R8: Error flag bit 2 is set when the sampled address differs from the previous sample while both samples are inside the same write.
- R9: Error flag bit 3 is set when the address changes in the write-end sample or in any of the next `MIN_REC`-1 samples.
- R10: Error flags are sticky. A flag stays set until `err_clear_i` is high on a clock edge. Violations detected on that same edge are recorded after the clear.
- R11: `err_code_o` is 0 while no flag is set. On the first violation after reset or a clear, it becomes the lowest violating flag index plus one and then holds until the next clear.
- R12: After reset all outputs are zero: mode deselected, no pulses, no flags, code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, much faster than the bus cycle |
| rst | input | 1 | Synchronous active-high reset |
| sel_lo_n_i | input | 1 | Active-low chip select line |
| sel_hi_i | input | 1 | Active-high chip select line |
| rd_en_n_i | input | 1 | Active-low output enable line |
| wr_en_n_i | input | 1 | Active-low write strobe line |
| addr_i | input | ADDR_W | Address lines |
| host_drive_i | input | 1 | High while the host drives the data lines |
| err_clear_i | input | 1 | Clears all flags and the code (clock domain of `clk`) |
| mode_o | output | 3 | Bus mode, 3 samples behind the pins |
| wr_start_o | output | 1 | One-cycle pulse at write start |
| wr_end_o | output | 1 | One-cycle pulse at write end |
| err_flags_o | output | 5 | Sticky violation flags |
| err_code_o | output | 3 | Code of the first violation since clear |

## Verification
The assertions assume that `err_clear_i` is driven in the sampling clock domain. They also assume that pins change at most once per sample period, so each bus edge lands in exactly one synchronised sample. The bench drives every input on the falling edge, and only in whole-cycle steps, which meets both assumptions. The directed part then steers each kind of write violation in turn. A longer randomised stretch toggles strobes, address, host drive and clear in arbitrary combinations, including overlapping writes and clears that fall on the same edge as a violation.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  typedef enum logic [2:0] {
    MODE_IDLE  = 3'd0,
    MODE_HIZ   = 3'd1,
    MODE_READ  = 3'd2,
    MODE_WRITE = 3'd3,
    MODE_CLASH = 3'd4
  } mode_e;

  localparam int NUM_ERR   = 5;
  localparam int ERR_PULSE = 0;
  localparam int ERR_SELW  = 1;
  localparam int ERR_ADDR  = 2;
  localparam int ERR_REC   = 3;
  localparam int ERR_CLASH = 4;

  typedef struct packed {
    logic lo_n;
    logic hi;
    logic rd_n;
    logic wr_n;
    logic drive;
  } pins_t;

  localparam pins_t PINS_IDLE = '{lo_n: 1'b1, hi: 1'b0, rd_n: 1'b1, wr_n: 1'b1, drive: 1'b0};
endpackage

// File: rtl/sbm_sync.sv
module sbm_sync #(
  parameter int W = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= {STAGES{RST_VAL}};
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sbm_decode.sv
module sbm_decode
  import sbm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  pins_t pins_i,
  output mode_e mode_o,
  output logic  clash_o
);
  logic  sel;
  mode_e mode_d;

  always_comb begin
    sel = ~pins_i.lo_n & pins_i.hi;
    if (!sel)              mode_d = MODE_IDLE;
    else if (!pins_i.wr_n) mode_d = MODE_WRITE;
    else if (!pins_i.rd_n) mode_d = pins_i.drive ? MODE_CLASH : MODE_READ;
    else                   mode_d = MODE_HIZ;
  end

  assign clash_o = sel & pins_i.wr_n & ~pins_i.rd_n & pins_i.drive;

  always_ff @(posedge clk) begin
    if (rst) mode_o <= MODE_IDLE;
    else     mode_o <= mode_d;
  end
endmodule

// File: rtl/sbm_write_check.sv
module sbm_write_check
  import sbm_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int MIN_WR_PULSE = 8,
  parameter int MIN_SEL_WIDTH = 10,
  parameter int MIN_REC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  pins_t             pins_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wr_start_o,
  output logic              wr_end_o,
  output logic [3:0]        viol_o
);
  localparam int LIM_MAX  = (MIN_WR_PULSE > MIN_SEL_WIDTH) ? MIN_WR_PULSE : MIN_SEL_WIDTH;
  localparam int CNT_W    = $clog2(LIM_MAX + 2);
  localparam int REC_W    = (MIN_REC > 1) ? $clog2(MIN_REC + 1) : 1;
  localparam int REC_LOAD = (MIN_REC > 0) ? MIN_REC - 1 : 0;

  logic              sel, act, act_q, start, fin, chg;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  pulse_cnt, sel_cnt;
  logic [REC_W-1:0]  rec_left;

  always_comb begin
    sel   = ~pins_i.lo_n & pins_i.hi;
    act   = sel & ~pins_i.wr_n;
    start = act & ~act_q;
    fin   = ~act & act_q;
    chg   = (addr_i != addr_q);
    viol_o[ERR_PULSE] = fin && (pulse_cnt < CNT_W'(MIN_WR_PULSE));
    viol_o[ERR_SELW]  = fin && (sel_cnt < CNT_W'(MIN_SEL_WIDTH));
    viol_o[ERR_ADDR]  = act && act_q && chg;
    viol_o[ERR_REC]   = chg && (fin ? (MIN_REC > 0) : (rec_left != '0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q      <= 1'b0;
      addr_q     <= '0;
      pulse_cnt  <= '0;
      sel_cnt    <= '0;
      rec_left   <= '0;
      wr_start_o <= 1'b0;
      wr_end_o   <= 1'b0;
    end else begin
      act_q      <= act;
      addr_q     <= addr_i;
      wr_start_o <= start;
      wr_end_o   <= fin;
      if (!act)                 pulse_cnt <= '0;
      else if (pulse_cnt != '1) pulse_cnt <= pulse_cnt + 1'b1;
      if (!sel)                 sel_cnt <= '0;
      else if (sel_cnt != '1)   sel_cnt <= sel_cnt + 1'b1;
      if (fin)                  rec_left <= REC_W'(REC_LOAD);
      else if (rec_left != '0)  rec_left <= rec_left - 1'b1;
    end
  end

  // R4: the previous sample stayed out of a write whenever a start fires
  p_start_after_idle_r4: assert property (@(posedge clk) disable iff (rst)
    wr_start_o |-> !$past(act_q));
endmodule

// File: rtl/sbm_err_log.sv
module sbm_err_log #(
  parameter int N = 5,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic [N-1:0]      viol_i,
  output logic [N-1:0]      flags_o,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] prio, base_code;

  always_comb begin
    prio = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (viol_i[i]) prio = CODE_W'(i + 1);
    end
    base_code = clr_i ? '0 : code_o;
  end

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) flags_o[g] <= 1'b0;
      else     flags_o[g] <= (flags_o[g] & ~clr_i) | viol_i[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                   code_o <= '0;
    else if (base_code == '0 && viol_i != '0) code_o <= prio;
    else                                       code_o <= base_code;
  end

  // R10: without a clear no flag falls
  p_flags_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(clr_i) |-> ((flags_o & $past(flags_o)) == $past(flags_o)));
  // R11: a code is held exactly while some flag is held
  p_code_with_flag_r11: assert property (@(posedge clk) disable iff (rst)
    (code_o != '0) == (flags_o != '0));
endmodule

// File: rtl/sram_bus_monitor.sv
module sram_bus_monitor
  import sbm_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int MIN_WR_PULSE = 8,
  parameter int MIN_SEL_WIDTH = 10,
  parameter int MIN_REC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_lo_n_i,
  input  logic              sel_hi_i,
  input  logic              rd_en_n_i,
  input  logic              wr_en_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              host_drive_i,
  input  logic              err_clear_i,
  output logic [2:0]        mode_o,
  output logic              wr_start_o,
  output logic              wr_end_o,
  output logic [4:0]        err_flags_o,
  output logic [2:0]        err_code_o
);
  localparam int PIN_W  = $bits(pins_t);
  localparam int SYNC_W = ADDR_W + PIN_W;

  logic [SYNC_W-1:0] raw, synced;
  pins_t             s_pins;
  logic [ADDR_W-1:0] s_addr;
  mode_e             mode_q;
  logic              clash;
  logic [3:0]        wr_viol;
  logic [NUM_ERR-1:0] viol;

  assign raw = {addr_i, sel_lo_n_i, sel_hi_i, rd_en_n_i, wr_en_n_i, host_drive_i};

  sbm_sync #(.W(SYNC_W), .STAGES(2), .RST_VAL({{ADDR_W{1'b0}}, PINS_IDLE})) i_sync (
    .clk(clk), .rst(rst), .d_i(raw), .q_o(synced));

  assign s_pins = synced[PIN_W-1:0];
  assign s_addr = synced[SYNC_W-1:PIN_W];

  sbm_decode i_decode (
    .clk(clk), .rst(rst), .pins_i(s_pins), .mode_o(mode_q), .clash_o(clash));

  sbm_write_check #(
    .ADDR_W(ADDR_W), .MIN_WR_PULSE(MIN_WR_PULSE),
    .MIN_SEL_WIDTH(MIN_SEL_WIDTH), .MIN_REC(MIN_REC)
  ) i_wchk (
    .clk(clk), .rst(rst), .pins_i(s_pins), .addr_i(s_addr),
    .wr_start_o(wr_start_o), .wr_end_o(wr_end_o), .viol_o(wr_viol));

  assign viol = {clash, wr_viol};

  sbm_err_log #(.N(NUM_ERR), .CODE_W(3)) i_log (
    .clk(clk), .rst(rst), .clr_i(err_clear_i), .viol_i(viol),
    .flags_o(err_flags_o), .code_o(err_code_o));

  assign mode_o = mode_q;

  // R4: start and end never coincide
  p_start_end_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(wr_start_o && wr_end_o));
  // R4: a start is reported together with write mode
  p_start_in_write_r4: assert property (@(posedge clk) disable iff (rst)
    wr_start_o |-> (mode_o == 3'd3));
  // R5: an end is reported outside write mode
  p_end_out_write_r5: assert property (@(posedge clk) disable iff (rst)
    wr_end_o |-> (mode_o != 3'd3));
  // R2: conflict mode always carries its flag
  p_clash_flagged_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd4) |-> err_flags_o[4]);
endmodule

// File: tb/test_sram_bus_monitor.sv
module test_sram_bus_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 18;
  localparam int MINP = 8;
  localparam int MINS = 10;
  localparam int MINR = 2;

  typedef struct packed {
    logic lo_n;
    logic hi;
    logic rd_n;
    logic wr_n;
    logic drive;
    logic [ADDR_W-1:0] addr;
  } smp_t;

  localparam smp_t IDLE = '{lo_n: 1'b1, hi: 1'b0, rd_n: 1'b1, wr_n: 1'b1, drive: 1'b0, addr: '0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic b_lo_n = 1'b1, b_hi = 1'b0, b_rd_n = 1'b1, b_wr_n = 1'b1, b_drive = 1'b0, b_clr = 1'b0;
  logic [ADDR_W-1:0] b_addr = '0;
  logic [2:0] mode_o;
  logic wr_start_o, wr_end_o;
  logic [4:0] err_flags_o;
  logic [2:0] err_code_o;

  int compared = 0;
  int mismatched = 0;
  bit started = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sram_bus_monitor #(.ADDR_W(ADDR_W), .MIN_WR_PULSE(MINP), .MIN_SEL_WIDTH(MINS), .MIN_REC(MINR)) i_sram_bus_monitor (
    .clk(clk), .rst(rst), .sel_lo_n_i(b_lo_n), .sel_hi_i(b_hi), .rd_en_n_i(b_rd_n),
    .wr_en_n_i(b_wr_n), .addr_i(b_addr), .host_drive_i(b_drive), .err_clear_i(b_clr),
    .mode_o(mode_o), .wr_start_o(wr_start_o), .wr_end_o(wr_end_o),
    .err_flags_o(err_flags_o), .err_code_o(err_code_o));

  // reference model state
  smp_t hist[$];
  int e_mode, e_start, e_end, e_flags, e_code;
  int m_act, m_pulse, m_sel, m_rec;
  logic [ADDR_W-1:0] m_addr;

  always @(posedge clk) begin
    smp_t d;
    int sel, act, fin, chg, v;
    started = 1;
    if (rst) begin
      hist = {};
      hist.push_back(IDLE);
      hist.push_back(IDLE);
      e_mode = 0; e_start = 0; e_end = 0; e_flags = 0; e_code = 0;
      m_act = 0; m_pulse = 0; m_sel = 0; m_rec = 0; m_addr = '0;
    end else begin
      hist.push_back('{lo_n: b_lo_n, hi: b_hi, rd_n: b_rd_n, wr_n: b_wr_n, drive: b_drive, addr: b_addr});
      d = hist.pop_front();
      sel = (!d.lo_n && d.hi) ? 1 : 0;
      act = (sel && !d.wr_n) ? 1 : 0;
      if (!sel) e_mode = 0;
      else if (!d.wr_n) e_mode = 3;
      else if (!d.rd_n) e_mode = d.drive ? 4 : 2;
      else e_mode = 1;
      fin = (!act && m_act) ? 1 : 0;
      e_start = (act && !m_act) ? 1 : 0;
      e_end = fin;
      chg = (d.addr != m_addr) ? 1 : 0;
      v = 0;
      if (fin && m_pulse < MINP) v = v | 1;
      if (fin && m_sel < MINS) v = v | 2;
      if (act && m_act && chg) v = v | 4;
      if (chg && (fin ? (MINR > 0) : (m_rec > 0))) v = v | 8;
      if (e_mode == 4) v = v | 16;
      if (b_clr) begin e_flags = 0; e_code = 0; end
      if (e_code == 0 && v != 0) begin
        for (int i = 4; i >= 0; i--) if (v[i]) e_code = i + 1;
      end
      e_flags = e_flags | v;
      m_pulse = act ? m_pulse + 1 : 0;
      m_sel = sel ? m_sel + 1 : 0;
      m_rec = fin ? ((MINR > 0) ? MINR - 1 : 0) : ((m_rec > 0) ? m_rec - 1 : 0);
      m_act = act;
      m_addr = d.addr;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R1 mode", int'(mode_o), e_mode);
      chk("R4 start", int'(wr_start_o), e_start);
      chk("R5 end", int'(wr_end_o), e_end);
      chk("R6-bit0 flags", int'(err_flags_o[0]), e_flags % 2);
      chk("R7 select-width flag", int'(err_flags_o[1]), (e_flags / 2) % 2);
      chk("R8 address flag", int'(err_flags_o[2]), (e_flags / 4) % 2);
      chk("R9 recovery flag", int'(err_flags_o[3]), (e_flags / 8) % 2);
      chk("R2 conflict flag", int'(err_flags_o[4]), (e_flags / 16) % 2);
      chk("R11 code", int'(err_code_o), e_code);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_errs();
    b_clr = 1'b1;
    step(1);
    b_clr = 1'b0;
    chk("R10 cleared flags", int'(err_flags_o), 0);
  endtask

  initial begin
    step(3);
    chk("R12 reset mode", int'(mode_o), 0);
    chk("R12 reset flags", int'(err_flags_o), 0);
    chk("R12 reset code", int'(err_code_o), 0);
    chk("R12 reset pulses", int'(wr_start_o) + int'(wr_end_o), 0);
    rst = 1'b0;
    step(5);
    // R3: read selected, visible only after the third edge
    b_lo_n = 1'b0; b_hi = 1'b1; b_rd_n = 1'b0;
    step(1); chk("R3 latency edge1", int'(mode_o), 0);
    step(1); chk("R3 latency edge2", int'(mode_o), 0);
    step(1); chk("R3 latency edge3", int'(mode_o), 2);
    b_rd_n = 1'b1; step(6);
    chk("R1 output disabled", int'(mode_o), 1);
    b_rd_n = 1'b0; b_drive = 1'b1; step(6);
    chk("R2 conflict mode", int'(mode_o), 4);
    chk("R2 conflict code", int'(err_code_o), 5);
    b_drive = 1'b0; step(2);
    clear_errs();
    // good write with read enable low
    b_addr = 18'd5; step(2);
    b_wr_n = 1'b0; step(12);
    chk("R1 write regardless of read enable", int'(mode_o), 3);
    b_wr_n = 1'b1; step(6);
    chk("R6 long write no flag", int'(err_flags_o), 0);
    // short pulse
    b_rd_n = 1'b1;
    b_wr_n = 1'b0; step(3); b_wr_n = 1'b1; step(6);
    chk("R6 short pulse flags", int'(err_flags_o), 1);
    step(5);
    chk("R10 flag held", int'(err_flags_o), 1);
    chk("R11 first code", int'(err_code_o), 1);
    clear_errs();
    // select too short, ended by the active-low select
    b_lo_n = 1'b1; step(4);
    b_lo_n = 1'b0; b_wr_n = 1'b0; step(9);
    b_lo_n = 1'b1; step(6);
    chk("R7 select short flags", int'(err_flags_o), 2);
    chk("R7 select short code", int'(err_code_o), 2);
    b_wr_n = 1'b1;
    clear_errs();
    // address change inside a write
    b_lo_n = 1'b0; step(3);
    b_wr_n = 1'b0; step(4);
    b_addr = 18'd6; step(8);
    b_wr_n = 1'b1; step(6);
    chk("R8 address flags", int'(err_flags_o), 4);
    chk("R8 address code", int'(err_code_o), 3);
    clear_errs();
    // address change one sample after write end
    b_wr_n = 1'b0; step(12);
    b_wr_n = 1'b1; step(1);
    b_addr = 18'd7; step(6);
    chk("R9 recovery flags", int'(err_flags_o), 8);
    chk("R9 recovery code", int'(err_code_o), 4);
    clear_errs();
    // write framed by the active-high select
    b_hi = 1'b0; step(4);
    b_wr_n = 1'b0; step(3);
    b_hi = 1'b1; step(12);
    b_hi = 1'b0; step(6);
    chk("R5 select-framed write clean", int'(err_flags_o), 0);
    b_wr_n = 1'b1; step(2);
    // random phase
    for (int c = 0; c < 3000; c++) begin
      if ($urandom_range(7) == 0) b_lo_n = ~b_lo_n;
      if ($urandom_range(7) == 0) b_hi = ~b_hi;
      if ($urandom_range(5) == 0) b_rd_n = ~b_rd_n;
      if ($urandom_range(5) == 0) b_wr_n = ~b_wr_n;
      if ($urandom_range(9) == 0) b_drive = ~b_drive;
      if ($urandom_range(15) == 0) b_addr = ADDR_W'($urandom_range(15));
      b_clr = ($urandom_range(63) == 0);
      step(1);
    end
    b_clr = 1'b0;
    step(4);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL R12 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule